// File: doc/BRIEF.md
# Byte-Wide SPI Master Peripheral

This block is an SPI master that sits behind a small 8-bit register bus. Software programs clock polarity, clock phase, bit order and a two-field clock divider, then writes a byte to the data register. That write starts an 8-bit full-duplex exchange on the serial pins. At the end of the exchange the received byte is available in the same register address, and a completion flag is raised.

Three sticky status flags report the block's condition: completion, write collision and mode fault. A write collision is a data write made while a byte is still shifting. A mode fault means the slave-select pin, configured as an input, was pulled low while the block is an enabled master. Each flag is cleared by a two-step access sequence, not by a plain write. Completion and mode fault each drive their own interrupt line, and both lines are gated by one enable bit. The slave-select pin is a general-purpose output controlled by a port data bit and a port direction bit.

Top module: `spi_host_regs`

## Requirements
- R1: After reset every register reads 0x00. Control 1 (0x00), control 2 (0x01), port data (0x0D) and port direction (0x10) read back what was written. The baud register (0x04) reads back only bits 6:4 and 2:0. Unused status bits read 0.
- R2: The baud register holds P in bits 6:4 and S in bits 2:0. Each SCK half period lasts (P+1)·2^S clocks, so a byte takes 16 half periods. The completion interrupt rises 16·(P+1)·2^S+1 clocks after the clock edge that accepts the data write.
- R3: Control 1 bit 3 (CPOL) sets the SCK idle level. With control 1 bit 2 (CPHA) at 0, MISO is sampled on the 1st, 3rd, … SCK edges and MOSI changes on the 2nd, 4th, …. With CPHA at 1, MISO is sampled on the even-numbered edges, and the first MOSI bit is valid no later than the first edge.
- R4: With control 1 bit 0 set, bit 0 is sent and received first. Otherwise bit 7 is first.
- R5: At the end of a byte the received value is loaded into the data register, and status bit 7 (done flag) is set. The flag clears only on a data register read that follows a status read made while the flag was set.
- R6: A data write while a byte is shifting sets status bit 6 (collision) and is discarded. The byte in flight completes unchanged. The collision flag clears on a data register read or write that follows a status read made while the flag was set.
- R7: When control 1 bit 6 (enable) and bit 4 (master) are set, port direction bit 3 is 0 and ss_n_i is low, status bit 4 (fault) is set and any byte in flight is abandoned. The fault flag clears only on a control 1 write that follows a status read made while the flag was set. No byte can start while the flag is set.
- R8: irq_done_o equals control 1 bit 7 AND the done flag. irq_fault_o equals control 1 bit 7 AND the fault flag.
- R9: ss_n_o follows port data bit 3 and ss_oe_o follows port direction bit 3.
- R10: Clearing the enable bit during a byte abandons it. SCK returns to the CPOL level, no done flag is raised, and the next byte runs normally.
- R11: A data write made while the enable bit or the master bit is 0 starts no transfer. SCK stays idle and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | 5 | Register address |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (drives read side effects) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select pin level, used for fault detection |
| ss_n_o | output | 1 | Slave-select output level |
| ss_oe_o | output | 1 | Slave-select output enable |
| irq_fault_o | output | 1 | Mode-fault interrupt |
| irq_done_o | output | 1 | Transfer-complete interrupt |

## Verification
Two conditions can only be reached with exact timing at the pins: a collision, which needs a second data write to land inside a slow byte, and an abort, which needs the enable bit cleared partway through a byte. The bench uses a slow divider and issues the second write, or the control write, a fixed number of bus cycles after the start. It then confirms the flags and that SCK is back at its idle level. The bench also contains a slave model that follows SCK. It lets the bench check, for every mode, that the byte the master sends and the byte it receives match the expected bit-order and edge choice.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
    localparam int unsigned DW    = 8;
    localparam int unsigned PRE_W = 3;
    localparam int unsigned SEL_W = 3;

    localparam logic [4:0] A_CTRL1 = 5'h00;
    localparam logic [4:0] A_CTRL2 = 5'h01;
    localparam logic [4:0] A_BAUD  = 5'h04;
    localparam logic [4:0] A_STAT  = 5'h05;
    localparam logic [4:0] A_DATA  = 5'h09;
    localparam logic [4:0] A_PORT  = 5'h0D;
    localparam logic [4:0] A_DIR   = 5'h10;

    localparam int unsigned C_IRQEN = 7;
    localparam int unsigned C_EN    = 6;
    localparam int unsigned C_MSTR  = 4;
    localparam int unsigned C_CPOL  = 3;
    localparam int unsigned C_CPHA  = 2;
    localparam int unsigned C_LSBF  = 0;
    localparam int unsigned P_SS    = 3;
endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
    parameter int unsigned PRE_W = 3,
    parameter int unsigned SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [PRE_W-1:0] pre_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned CNT_W = PRE_W + (1 << SEL_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } baud_st_t;

    baud_st_t q, d;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = ((CNT_W'(pre_i) + CNT_W'(1)) << sel_i) - CNT_W'(1);
        tick_o  = run_i && (q.cnt == half_m1);
        d       = q;
        if (!run_i || tick_o) d.cnt = '0;
        else                  d.cnt = q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R2: the half-period counter never passes its terminal value while running
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $stable(pre_i) && $stable(sel_i) && $past(run_i)) |-> (q.cnt <= half_m1));
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          abort_i,
    input  logic          tick_i,
    input  logic          cpol_i,
    input  logic          cpha_i,
    input  logic          lsbf_i,
    input  logic [DW-1:0] tx_i,
    input  logic          miso_i,
    output logic          busy_o,
    output logic          sck_o,
    output logic          mosi_o,
    output logic          done_o,
    output logic [DW-1:0] rx_o
);
    localparam int unsigned EDGES = 2 * DW;
    localparam int unsigned EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST = EW'(EDGES - 1);

    typedef struct packed {
        logic          busy;
        logic [EW-1:0] edge_n;
        logic          sck;
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic          done;
    } shift_st_t;

    shift_st_t q, d;
    logic      sample;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        sample = cpha_i ? q.edge_n[0] : ~q.edge_n[0];
        if (abort_i) begin
            d.busy   = 1'b0;
            d.edge_n = '0;
            d.sck    = cpol_i;
        end else if (!q.busy) begin
            if (start_i) begin
                d.busy   = 1'b1;
                d.edge_n = '0;
                d.sck    = cpol_i;
                d.tx     = tx_i;
            end
        end else if (tick_i) begin
            d.sck    = ~q.sck;
            d.edge_n = q.edge_n + EW'(1);
            if (sample)
                d.rx = lsbf_i ? {miso_i, q.rx[DW-1:1]} : {q.rx[DW-2:0], miso_i};
            else if (q.edge_n != '0 && q.edge_n != LAST)
                d.tx = lsbf_i ? (q.tx >> 1) : (q.tx << 1);
            if (q.edge_n == LAST) begin
                d.busy   = 1'b0;
                d.edge_n = '0;
                d.done   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy_o = q.busy;
    assign sck_o  = q.busy ? q.sck : cpol_i;
    assign mosi_o = lsbf_i ? q.tx[0] : q.tx[DW-1];
    assign done_o = q.done;
    assign rx_o   = q.rx;

    // R3: SCK only moves on a divider tick
    a_r3_sck_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick_i && !abort_i) |=> (q.sck == $past(q.sck)));
    // R5: completion only follows an active byte
    a_r5_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.busy && $past(q.busy)));
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o,
    output logic              sck_o,
    output logic              mosi_o,
    input  logic              miso_i,
    input  logic              ss_n_i,
    output logic              ss_n_o,
    output logic              ss_oe_o,
    output logic              irq_fault_o,
    output logic              irq_done_o
);
    typedef struct packed {
        logic [DW-1:0]    ctrl1;
        logic [DW-1:0]    ctrl2;
        logic [PRE_W-1:0] pre;
        logic [SEL_W-1:0] sel;
        logic [DW-1:0]    port;
        logic [DW-1:0]    dir;
        logic [DW-1:0]    rxd;
        logic             spif, wcol, modf;
        logic             spif_arm, wcol_arm, modf_arm;
    } reg_st_t;

    reg_st_t q, d;

    logic          busy, tick, done, abort, start, modf_set;
    logic          en, mstr, data_wr, data_rd;
    logic [DW-1:0] rx;

    assign en       = q.ctrl1[C_EN];
    assign mstr     = q.ctrl1[C_MSTR];
    assign data_wr  = wr_i && (addr_i == ADDR_W'(A_DATA));
    assign data_rd  = rd_i && (addr_i == ADDR_W'(A_DATA));
    assign modf_set = en && mstr && !q.dir[P_SS] && !ss_n_i;
    assign abort    = !en || modf_set;
    assign start    = data_wr && !busy && en && mstr && !q.modf && !modf_set;

    spi_host_baud #(.PRE_W(PRE_W), .SEL_W(SEL_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run_i(busy),
        .pre_i(q.pre), .sel_i(q.sel), .tick_o(tick)
    );

    spi_host_shift #(.DW(DW)) u_shift (
        .clk(clk), .rst_n(rst_n), .start_i(start), .abort_i(abort),
        .tick_i(tick), .cpol_i(q.ctrl1[C_CPOL]), .cpha_i(q.ctrl1[C_CPHA]),
        .lsbf_i(q.ctrl1[C_LSBF]), .tx_i(wdata_i), .miso_i(miso_i),
        .busy_o(busy), .sck_o(sck_o), .mosi_o(mosi_o), .done_o(done), .rx_o(rx)
    );

    always_comb begin
        d = q;
        if (wr_i) begin
            unique case (addr_i)
                ADDR_W'(A_CTRL1): d.ctrl1 = wdata_i;
                ADDR_W'(A_CTRL2): d.ctrl2 = wdata_i;
                ADDR_W'(A_BAUD): begin
                    d.pre = wdata_i[4 +: PRE_W];
                    d.sel = wdata_i[0 +: SEL_W];
                end
                ADDR_W'(A_PORT): d.port = wdata_i;
                ADDR_W'(A_DIR):  d.dir  = wdata_i;
                default: ;
            endcase
        end
        // first step of each clear sequence
        if (rd_i && addr_i == ADDR_W'(A_STAT)) begin
            d.spif_arm = q.spif_arm | q.spif;
            d.wcol_arm = q.wcol_arm | q.wcol;
            d.modf_arm = q.modf_arm | q.modf;
        end
        // second step
        if (data_rd && q.spif_arm) begin
            d.spif     = 1'b0;
            d.spif_arm = 1'b0;
        end
        if ((data_rd || data_wr) && q.wcol_arm) begin
            d.wcol     = 1'b0;
            d.wcol_arm = 1'b0;
        end
        if (wr_i && addr_i == ADDR_W'(A_CTRL1) && q.modf_arm) begin
            d.modf     = 1'b0;
            d.modf_arm = 1'b0;
        end
        // raising events win over clears
        if (done) begin
            d.rxd      = rx;
            d.spif     = 1'b1;
            d.spif_arm = 1'b0;
        end
        if (data_wr && busy) begin
            d.wcol     = 1'b1;
            d.wcol_arm = 1'b0;
        end
        if (modf_set) begin
            d.modf     = 1'b1;
            d.modf_arm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (addr_i)
            ADDR_W'(A_CTRL1): rdata_o = q.ctrl1;
            ADDR_W'(A_CTRL2): rdata_o = q.ctrl2;
            ADDR_W'(A_BAUD):  rdata_o = {1'b0, q.pre, 1'b0, q.sel};
            ADDR_W'(A_STAT):  rdata_o = {q.spif, q.wcol, 1'b0, q.modf, 4'b0000};
            ADDR_W'(A_DATA):  rdata_o = q.rxd;
            ADDR_W'(A_PORT):  rdata_o = q.port;
            ADDR_W'(A_DIR):   rdata_o = q.dir;
            default:          rdata_o = '0;
        endcase
    end

    assign ss_n_o      = q.port[P_SS];
    assign ss_oe_o     = q.dir[P_SS];
    assign irq_done_o  = q.ctrl1[C_IRQEN] & q.spif;
    assign irq_fault_o = q.ctrl1[C_IRQEN] & q.modf;

    // R6: a data write during a byte leaves the collision flag set
    a_r6_wcol_on_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && busy) |=> q.wcol);
    // R7: slave-select pulled low in master mode raises the fault
    a_r7_modf_on_ss_low: assert property (@(posedge clk) disable iff (!rst_n)
        modf_set |=> q.modf);
    // R7: no shifting while a fault is pending
    a_r7_modf_blocks_shift: assert property (@(posedge clk) disable iff (!rst_n)
        q.modf |-> !busy);
    // R5: the done flag only drops through a data read after arming
    a_r5_spif_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.spif) |-> $past(data_rd && q.spif_arm));
    // R11: with the block disabled the shifter goes idle
    a_r11_off_is_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy);
endmodule

// File: tb/spi_host_regs_bench.sv
module spi_host_regs_bench;
    import spi_host_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       sck, mosi, miso, ss_in = 1'b1, ss_out, ss_oe, irq_f, irq_d;

    int n_tests = 0;
    int n_fail  = 0;

    // slave model state
    logic       s_act = 1'b0;
    logic       s_cpha = 1'b0, s_lsb = 1'b0;
    logic [7:0] s_out = '0, s_cap = '0;
    logic [2:0] s_idx = '0;
    int         s_k = 0;
    logic [7:0] exp_tx[$];

    always #2 clk = ~clk;

    assign miso = s_out[s_lsb ? s_idx : 3'(7 - s_idx)];

    spi_host_regs u_spi_host_regs (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
        .miso_i(miso), .ss_n_i(ss_in), .ss_n_o(ss_out), .ss_oe_o(ss_oe),
        .irq_fault_o(irq_f), .irq_done_o(irq_d)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [7:0] v);
        @(negedge clk); addr = a; wdata = v; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_d && n < 40000) begin
            @(negedge clk); n++;
        end
    endtask

    task automatic arm_slave(input logic cpha, input logic lsb, input logic [7:0] sl);
        s_cpha = cpha; s_lsb = lsb; s_out = sl; s_cap = '0; s_idx = '0; s_k = 0;
        s_act = 1'b1;
    endtask

    // driver: configures, queues the expected MOSI byte, checks timing and RX
    task automatic xfer(input logic cpol, input logic cpha, input logic lsb,
                        input logic [7:0] baud, input logic [7:0] tx,
                        input logic [7:0] sl, input int exp_n);
        logic [7:0] v;
        int n;
        wr_reg(A_CTRL1, 8'hD0 | {4'b0, cpol, cpha, 1'b0, lsb});
        wr_reg(A_BAUD, baud);
        arm_slave(cpha, lsb, sl);
        exp_tx.push_back(tx);
        wr_reg(A_DATA, tx);
        wait_irq(n);
        chk("R2 byte duration", n, exp_n);
        chk("R3 idle level", int'(sck), int'(cpol));
        rd_reg(A_STAT, v); chk("R5 done flag", v, 8'h80);
        rd_reg(A_DATA, v); chk("R3/R4 received byte", v, sl);
        rd_reg(A_STAT, v); chk("R5 flag cleared", v, 8'h00);
    endtask

    // monitor: slave side, captures MOSI and compares with the queue
    initial begin
        forever begin
            @(sck);
            if (s_act && rst_n) begin
                if (s_cpha ? (s_k % 2 == 1) : (s_k % 2 == 0))
                    s_cap[s_lsb ? (s_k / 2) : (7 - s_k / 2)] = mosi;
                else if ((s_cpha ? s_k / 2 : (s_k + 1) / 2) < 8)
                    s_idx = 3'(s_cpha ? s_k / 2 : (s_k + 1) / 2);
                if (s_k == 15) begin
                    s_act = 1'b0;
                    if (exp_tx.size() == 0) chk("R3 unexpected byte", 1, 0);
                    else chk("R3/R4 sent byte", s_cap, exp_tx.pop_front());
                end
                s_k++;
            end
        end
    end

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset state
        rd_reg(A_CTRL1, v); chk("R1 ctrl1 reset", v, 0);
        rd_reg(A_STAT, v);  chk("R1 status reset", v, 0);
        rd_reg(A_BAUD, v);  chk("R1 baud reset", v, 0);
        chk("R1 sck reset", int'(sck), 0);
        chk("R8 irq reset", int'({irq_d, irq_f}), 0);

        // R1 readback
        wr_reg(A_CTRL2, 8'h5A); rd_reg(A_CTRL2, v); chk("R1 ctrl2", v, 8'h5A);
        wr_reg(A_BAUD, 8'hFF);  rd_reg(A_BAUD, v);  chk("R1 baud mask", v, 8'h77);
        wr_reg(A_PORT, 8'h08);  rd_reg(A_PORT, v);  chk("R1 port", v, 8'h08);
        wr_reg(A_DIR, 8'h08);   rd_reg(A_DIR, v);   chk("R1 dir", v, 8'h08);

        // R9 slave-select as output
        chk("R9 ss oe", int'(ss_oe), 1);
        chk("R9 ss high", int'(ss_out), 1);
        wr_reg(A_PORT, 8'h00); chk("R9 ss low", int'(ss_out), 0);
        wr_reg(A_PORT, 8'h08); chk("R9 ss high again", int'(ss_out), 1);

        // R11 no start when disabled or not master
        wr_reg(A_BAUD, 8'h00);
        wr_reg(A_CTRL1, 8'h10); wr_reg(A_DATA, 8'hAA);
        repeat (40) @(negedge clk);
        chk("R11 sck idle (off)", int'(sck), 0);
        rd_reg(A_STAT, v); chk("R11 no flag (off)", v, 0);
        wr_reg(A_CTRL1, 8'h40); wr_reg(A_DATA, 8'hAA);
        repeat (40) @(negedge clk);
        rd_reg(A_STAT, v); chk("R11 no flag (slave)", v, 0);

        // R2 R3 R4 transfers across modes and dividers
        xfer(1'b0, 1'b0, 1'b0, 8'h00, 8'hA5, 8'h3C, 17);
        xfer(1'b0, 1'b1, 1'b0, 8'h00, 8'h5A, 8'hC3, 17);
        xfer(1'b1, 1'b0, 1'b1, 8'h21, 8'h96, 8'h1E, 97);
        xfer(1'b1, 1'b1, 1'b1, 8'h10, 8'h01, 8'h80, 33);
        xfer(1'b0, 1'b0, 1'b1, 8'h77, 8'hF0, 8'h0F, 16385);

        // R5 data read alone does not clear
        wr_reg(A_CTRL1, 8'hD0); wr_reg(A_BAUD, 8'h00);
        arm_slave(1'b0, 1'b0, 8'h66); exp_tx.push_back(8'h33);
        wr_reg(A_DATA, 8'h33); wait_irq(n);
        rd_reg(A_DATA, v); chk("R5 rx latched", v, 8'h66);
        rd_reg(A_STAT, v); chk("R5 still set without sequence", v, 8'h80);
        rd_reg(A_DATA, v);
        chk("R8 done irq dropped", int'(irq_d), 0);

        // R8 interrupt gated off
        wr_reg(A_CTRL1, 8'h50);
        arm_slave(1'b0, 1'b0, 8'h81); exp_tx.push_back(8'h18);
        wr_reg(A_DATA, 8'h18);
        repeat (40) @(negedge clk);
        chk("R8 done irq gated", int'(irq_d), 0);
        rd_reg(A_STAT, v); chk("R8 flag still set", v, 8'h80);
        rd_reg(A_DATA, v);

        // R6 collision
        wr_reg(A_CTRL1, 8'hD0); wr_reg(A_BAUD, 8'h21);
        arm_slave(1'b0, 1'b0, 8'h4B); exp_tx.push_back(8'h69);
        wr_reg(A_DATA, 8'h69);
        wr_reg(A_DATA, 8'hFF);
        wait_irq(n);
        rd_reg(A_STAT, v); chk("R6 collision and done", v, 8'hC0);
        rd_reg(A_DATA, v); chk("R6 byte undisturbed", v, 8'h4B);
        rd_reg(A_STAT, v); chk("R6 collision cleared", v, 8'h00);

        // R10 abort by clearing enable
        arm_slave(1'b0, 1'b0, 8'h00);
        wr_reg(A_DATA, 8'h77);
        repeat (30) @(negedge clk);
        s_act = 1'b0;
        wr_reg(A_CTRL1, 8'h88);
        @(negedge clk);
        chk("R10 sck to idle", int'(sck), 1);
        repeat (200) @(negedge clk);
        rd_reg(A_STAT, v); chk("R10 no done flag", v, 8'h00);
        xfer(1'b0, 1'b0, 1'b0, 8'h00, 8'hC7, 8'h5E, 17);

        // R7 mode fault
        wr_reg(A_DIR, 8'h00); wr_reg(A_BAUD, 8'h21);
        wr_reg(A_DATA, 8'h12);
        repeat (10) @(negedge clk);
        ss_in = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 fault irq", int'(irq_f), 1);
        chk("R7 sck idle after fault", int'(sck), 0);
        ss_in = 1'b1;
        wr_reg(A_CTRL1, 8'hD0);
        rd_reg(A_STAT, v); chk("R7 fault kept without sequence", v, 8'h10);
        wr_reg(A_CTRL1, 8'hD0);
        rd_reg(A_STAT, v); chk("R7 fault cleared", v, 8'h00);
        chk("R8 fault irq low", int'(irq_f), 0);
        wr_reg(A_DIR, 8'h08);

        finish_run();
    end
endmodule